// File: doc/BRIEF.md
# Channel-Tagged Mailbox Request Dispatcher

This block connects a CPU's mailbox write window to a set of peripheral channels. Each word the CPU writes into the request window carries its destination channel in its low four bits. The dispatcher hands the word straight to that channel when the channel is idle. When the channel is busy, the word goes into the outbound mailbox, and it is forwarded later, oldest first, once its channel goes idle. A word whose tag names no channel is dropped. A word that arrives while the outbound mailbox is full is also dropped.

In the other direction, each channel raises an available line while it holds a response word. While the inbound mailbox has space, the dispatcher fetches one word per cycle from the lowest-numbered available channel and pushes it inbound. A channel is therefore drained for as long as it stays available before any higher-numbered channel is served. Both mailboxes are external FIFOs. The block sees only their push, pop, head and flag signals.

Top module: `mbx_dispatch`

## Requirements
- R1: A request is a CPU write whose address is 0xA0, 0xA4, 0xA8 or 0xAC. It is registered on the write edge and acted on during the following cycle. Writes to any other address, including unaligned addresses inside 0xA0..0xAF, have no effect.
- R2: While `obFull` is high in the action cycle, a request is discarded. No push and no channel strobe occur, whatever the request's channel.
- R3: A request whose tag (bits 3:0 of the word) is not below `CH_COUNT` (9 by default) is discarded.
- R4: If the tagged channel's `chBusy` bit is high in the action cycle, the whole 32-bit word is pushed to the outbound mailbox through `obPush`/`obPushData`.
- R5: If the tagged channel is idle, `chReq` pulses the one bit matching the tag for that cycle, with `chReqData` equal to the word.
- R6: While any `chAvail` bit is high and `ibFull` is low, exactly one `chFetch` bit is raised each cycle, for the lowest-indexed available channel. In the same cycle `ibPush` is high and `ibPushData` equals that channel's `chRspData` slice (bits 32*i+31:32*i).
- R7: While `ibFull` is high, no `chFetch` bit is raised.
- R8: When no request is pending, the outbound mailbox is not empty, and the head word's channel (`obHead` bits 3:0) is idle, the head word is forwarded. `obPop` is high and `chReq`/`chReqData` deliver the word, one word per cycle. A pending request takes the cycle first.
- R9: While `rstN` is low, all strobe outputs (`chReq`, `chFetch`, `obPush`, `obPop`, `ibPush`) are low.
- R10: No fetched response word equals the invalid marker 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWrEn | input | 1 | CPU write strobe |
| cpuWrAddr | input | 8 | CPU write byte offset |
| cpuWrData | input | 32 | CPU write data |
| obFull | input | 1 | Outbound mailbox full |
| obEmpty | input | 1 | Outbound mailbox empty |
| obHead | input | 32 | Oldest outbound word |
| obPush | output | 1 | Push into outbound mailbox |
| obPushData | output | 32 | Word pushed outbound |
| obPop | output | 1 | Pop the oldest outbound word |
| ibFull | input | 1 | Inbound mailbox full |
| ibPush | output | 1 | Push into inbound mailbox |
| ibPushData | output | 32 | Word pushed inbound |
| chBusy | input | CH_COUNT | Per-channel busy flags |
| chAvail | input | CH_COUNT | Per-channel response available |
| chRspData | input | CH_COUNT*32 | Per-channel response word, channel i at bits 32*i+31:32*i |
| chReq | output | CH_COUNT | Per-channel request strobe |
| chReqData | output | 32 | Request word for the strobed channel |
| chFetch | output | CH_COUNT | Per-channel response fetch strobe |

## Verification
The assertions assume well-behaved neighbours. The outbound FIFO reports full and empty truthfully. A channel lowers `chAvail` by the cycle after its last word is fetched. An available channel never presents the invalid marker. The stimulus keeps to this through bench models. A FIFO model drives the mailbox flags from its own count. Each channel model derives `chAvail` from a registered read pointer that advances on `chFetch`. Response words are loaded only with values whose low nibble is not 0xF. Busy flags and loads change at falling edges only, so the dispatcher sees stable inputs for a whole cycle.

// File: rtl/mbx_disp_pkg.sv
`timescale 1ns/1ps
package mbx_disp_pkg;
  localparam int TAG_W  = 4;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] WIN_LO = 8'hA0;
  localparam logic [ADDR_W-1:0] WIN_HI = 8'hAC;

  typedef struct packed {
    logic             capture;
    logic             direct;
    logic             enqueue;
    logic             forward;
    logic             fetch;
    logic [TAG_W-1:0] reqSel;
    logic [TAG_W-1:0] rspSel;
  } disp_strobe_t;
endpackage

// File: rtl/mbx_disp_ctrl.sv
`timescale 1ns/1ps
module mbx_disp_ctrl
  import mbx_disp_pkg::*;
#(
  parameter int CH_COUNT = 9
) (
  input  logic                 live,
  input  logic                 cpuWrEn,
  input  logic [ADDR_W-1:0]    cpuWrAddr,
  input  logic                 pendValid,
  input  logic [TAG_W-1:0]     pendTag,
  input  logic                 obFull,
  input  logic                 obEmpty,
  input  logic [TAG_W-1:0]     headTag,
  input  logic                 ibFull,
  input  logic [CH_COUNT-1:0]  chBusy,
  input  logic [CH_COUNT-1:0]  chAvail,
  output disp_strobe_t         strobe
);
  localparam int TAG_SPAN = 1 << TAG_W;

  logic [TAG_SPAN-1:0] busyWide;
  logic                pendOk;
  logic                headOk;
  logic [TAG_W-1:0]    lowAvail;

  assign busyWide = TAG_SPAN'(chBusy);
  assign pendOk   = pendValid && !obFull && (int'(pendTag) < CH_COUNT);
  assign headOk   = !obEmpty && (int'(headTag) < CH_COUNT) && !busyWide[headTag];

  always_comb begin
    lowAvail = '0;
    for (int i = CH_COUNT - 1; i >= 0; i--) begin
      if (chAvail[i]) lowAvail = TAG_W'(i);
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.capture = cpuWrEn && (cpuWrAddr >= WIN_LO) && (cpuWrAddr <= WIN_HI)
                     && (cpuWrAddr[1:0] == 2'b00);
    strobe.direct  = pendOk && !busyWide[pendTag];
    strobe.enqueue = pendOk && busyWide[pendTag];
    strobe.forward = live && !pendValid && headOk;
    strobe.reqSel  = pendValid ? pendTag : headTag;
    strobe.fetch   = live && (|chAvail) && !ibFull;
    strobe.rspSel  = lowAvail;
  end
endmodule

// File: rtl/mbx_disp_path.sv
`timescale 1ns/1ps
module mbx_disp_path
  import mbx_disp_pkg::*;
#(
  parameter int CH_COUNT = 9,
  parameter int DW       = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  disp_strobe_t           strobe,
  input  logic [DW-1:0]          cpuWrData,
  input  logic [DW-1:0]          obHead,
  input  logic [CH_COUNT*DW-1:0] chRspData,
  output logic                   pendValid,
  output logic [TAG_W-1:0]       pendTag,
  output logic                   obPush,
  output logic [DW-1:0]          obPushData,
  output logic                   obPop,
  output logic                   ibPush,
  output logic [DW-1:0]          ibPushData,
  output logic [CH_COUNT-1:0]    chReq,
  output logic [DW-1:0]          chReqData,
  output logic [CH_COUNT-1:0]    chFetch
);
  logic [DW-1:0] pendData;
  logic          reqFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendData  <= '0;
    end else begin
      pendValid <= strobe.capture;
      if (strobe.capture) pendData <= cpuWrData;
    end
  end

  assign pendTag    = pendData[TAG_W-1:0];
  assign reqFire    = strobe.direct || strobe.forward;
  assign obPush     = strobe.enqueue;
  assign obPushData = pendData;
  assign obPop      = strobe.forward;
  assign chReqData  = strobe.forward ? obHead : pendData;
  assign ibPush     = strobe.fetch;

  for (genvar i = 0; i < CH_COUNT; i++) begin : g_chan
    assign chReq[i]   = reqFire && (strobe.reqSel == TAG_W'(i));
    assign chFetch[i] = strobe.fetch && (strobe.rspSel == TAG_W'(i));
  end

  always_comb begin
    ibPushData = '0;
    for (int i = 0; i < CH_COUNT; i++) begin
      if (strobe.rspSel == TAG_W'(i)) ibPushData = chRspData[i*DW +: DW];
    end
  end
endmodule

// File: rtl/mbx_dispatch.sv
`timescale 1ns/1ps
module mbx_dispatch
  import mbx_disp_pkg::*;
#(
  parameter int CH_COUNT = 9,
  parameter int DW       = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cpuWrEn,
  input  logic [7:0]             cpuWrAddr,
  input  logic [DW-1:0]          cpuWrData,
  input  logic                   obFull,
  input  logic                   obEmpty,
  input  logic [DW-1:0]          obHead,
  output logic                   obPush,
  output logic [DW-1:0]          obPushData,
  output logic                   obPop,
  input  logic                   ibFull,
  output logic                   ibPush,
  output logic [DW-1:0]          ibPushData,
  input  logic [CH_COUNT-1:0]    chBusy,
  input  logic [CH_COUNT-1:0]    chAvail,
  input  logic [CH_COUNT*DW-1:0] chRspData,
  output logic [CH_COUNT-1:0]    chReq,
  output logic [DW-1:0]          chReqData,
  output logic [CH_COUNT-1:0]    chFetch
);
  disp_strobe_t     strobe;
  logic             pendValid;
  logic [TAG_W-1:0] pendTag;

  mbx_disp_ctrl #(.CH_COUNT(CH_COUNT)) u_ctrl (
    .live(rstN), .cpuWrEn(cpuWrEn), .cpuWrAddr(cpuWrAddr),
    .pendValid(pendValid), .pendTag(pendTag),
    .obFull(obFull), .obEmpty(obEmpty), .headTag(obHead[TAG_W-1:0]),
    .ibFull(ibFull), .chBusy(chBusy), .chAvail(chAvail), .strobe(strobe)
  );

  mbx_disp_path #(.CH_COUNT(CH_COUNT), .DW(DW)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cpuWrData(cpuWrData),
    .obHead(obHead), .chRspData(chRspData),
    .pendValid(pendValid), .pendTag(pendTag),
    .obPush(obPush), .obPushData(obPushData), .obPop(obPop),
    .ibPush(ibPush), .ibPushData(ibPushData),
    .chReq(chReq), .chReqData(chReqData), .chFetch(chFetch)
  );
endmodule

// File: rtl/mbx_dispatch_checker.sv
`timescale 1ns/1ps
module mbx_dispatch_checker #(
  parameter int          CH_COUNT     = 9,
  parameter int          DW           = 32,
  parameter logic [31:0] INVALID_WORD = 32'hFFFF_FFFF
) (
  input logic                clk,
  input logic                rstN,
  input logic                cpuWrEn,
  input logic [7:0]          cpuWrAddr,
  input logic                obFull,
  input logic [DW-1:0]       obHead,
  input logic                obPush,
  input logic                obPop,
  input logic                ibFull,
  input logic                ibPush,
  input logic [DW-1:0]       ibPushData,
  input logic [CH_COUNT-1:0] chBusy,
  input logic [CH_COUNT-1:0] chAvail,
  input logic [CH_COUNT-1:0] chReq,
  input logic [DW-1:0]       chReqData,
  input logic [CH_COUNT-1:0] chFetch
);
  // R9
  a_r9_quiet_in_reset: assert property (@(posedge clk)
    !rstN |-> (chReq == '0 && chFetch == '0 && !obPush && !obPop && !ibPush));

  // R1
  a_r1_push_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    obPush |-> $past(cpuWrEn && cpuWrAddr[7:4] == 4'hA));

  // R2
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    obFull |-> !obPush);

  // R4
  a_r4_no_req_to_busy: assert property (@(posedge clk) disable iff (!rstN)
    (chReq & chBusy) == '0);

  // R5
  a_r5_req_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chReq));

  // R6
  a_r6_fetch_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chFetch));

  // R6
  a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rstN)
    (chFetch != '0) |-> (((chFetch - 1'b1) & chAvail) == '0 && (chFetch & chAvail) != '0 && ibPush));

  // R7
  a_r7_hold_when_full: assert property (@(posedge clk) disable iff (!rstN)
    ibFull |-> (chFetch == '0));

  // R8
  a_r8_pop_delivers_head: assert property (@(posedge clk) disable iff (!rstN)
    obPop |-> ($onehot(chReq) && chReqData == obHead));

  // R10
  a_r10_no_invalid_fetch: assert property (@(posedge clk) disable iff (!rstN)
    ibPush |-> (ibPushData != INVALID_WORD));
endmodule

bind mbx_dispatch mbx_dispatch_checker #(.CH_COUNT(CH_COUNT), .DW(DW)) u_checker (
  .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuWrAddr(cpuWrAddr),
  .obFull(obFull), .obHead(obHead), .obPush(obPush), .obPop(obPop),
  .ibFull(ibFull), .ibPush(ibPush), .ibPushData(ibPushData),
  .chBusy(chBusy), .chAvail(chAvail), .chReq(chReq),
  .chReqData(chReqData), .chFetch(chFetch)
);

// File: tb/mbx_dispatch_bench.sv
`timescale 1ns/1ps
module mbx_dispatch_bench;
  localparam int CLK_PERIOD = 8;
  localparam int SAMPLE_DLY = 6;
  localparam int CH = 9;
  localparam int DW = 32;
  localparam int OB_DEPTH = 4;
  localparam int IB_DEPTH = 4;
  localparam int RSP_DEPTH = 8;
  localparam logic [31:0] INVALID = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuWrEn = 1'b0;
  logic [7:0] cpuWrAddr = '0;
  logic [DW-1:0] cpuWrData = '0;
  logic obFull, obEmpty, obPush, obPop, ibFull, ibPush;
  logic [DW-1:0] obHead, obPushData, ibPushData, chReqData;
  logic [CH-1:0] chBusy = '0;
  logic [CH-1:0] chAvail, chReq, chFetch;
  logic [CH*DW-1:0] chRspData;
  logic holdRsp = 1'b0;

  int vectors = 0;
  int miscompares = 0;

  // Mailbox and channel models
  logic [DW-1:0] obMem [OB_DEPTH];
  int obCnt = 0;
  int ibCnt = 0;
  logic [DW-1:0] rspMem [CH][RSP_DEPTH];
  int rspCnt [CH];
  int rspRd  [CH];

  assign obFull  = (obCnt >= OB_DEPTH);
  assign obEmpty = (obCnt == 0);
  assign obHead  = obMem[0];
  assign ibFull  = (ibCnt >= IB_DEPTH);

  for (genvar i = 0; i < CH; i++) begin : g_model
    assign chAvail[i] = !holdRsp && (rspRd[i] < rspCnt[i]);
    assign chRspData[i*DW +: DW] = rspMem[i][rspRd[i] % RSP_DEPTH];
  end

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_dispatch #(.CH_COUNT(CH), .DW(DW)) u_mbx_dispatch (
    .clk(clk), .rstN(rstN), .cpuWrEn(cpuWrEn), .cpuWrAddr(cpuWrAddr),
    .cpuWrData(cpuWrData), .obFull(obFull), .obEmpty(obEmpty), .obHead(obHead),
    .obPush(obPush), .obPushData(obPushData), .obPop(obPop),
    .ibFull(ibFull), .ibPush(ibPush), .ibPushData(ibPushData),
    .chBusy(chBusy), .chAvail(chAvail), .chRspData(chRspData),
    .chReq(chReq), .chReqData(chReqData), .chFetch(chFetch)
  );

  initial begin
    for (int i = 0; i < CH; i++) begin rspCnt[i] = 0; rspRd[i] = 0; end
    for (int k = 0; k < OB_DEPTH; k++) obMem[k] = '0;
  end

  always @(posedge clk) begin
    for (int i = 0; i < CH; i++) if (chFetch[i]) rspRd[i] <= rspRd[i] + 1;
    if (ibPush) ibCnt <= ibCnt + 1;
    if (obPop) for (int k = 0; k < OB_DEPTH - 1; k++) obMem[k] <= obMem[k+1];
    if (obPush && (obCnt - int'(obPop)) < OB_DEPTH) obMem[obCnt - int'(obPop)] <= obPushData;
    obCnt <= obCnt + int'(obPush) - int'(obPop);
  end

  // Scoreboard queues
  logic [DW-1:0] expReq[$];
  string         expReqTag[$];
  logic [DW-1:0] expOb[$];
  string         expObTag[$];
  logic [DW-1:0] expIb[$];
  string         expIbTag[$];

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: compares what the design produces against expected queues
  always @(posedge clk) begin
    #(SAMPLE_DLY);
    if (rstN) begin
      if (chReq != '0) begin
        check($onehot(chReq), "R5 one-hot chReq", DW'(chReq), '0);
        check(chReq[chReqData[3:0]], "R5 strobe matches tag", DW'(chReq), DW'(1) << chReqData[3:0]);
        if (expReq.size() == 0) check(1'b0, "R1/R3 unexpected request", chReqData, '0);
        else begin
          string t;
          logic [DW-1:0] e;
          e = expReq.pop_front();
          t = expReqTag.pop_front();
          check(chReqData == e, t, chReqData, e);
        end
      end
      if (obPush) begin
        if (expOb.size() == 0) check(1'b0, "R2 unexpected outbound push", obPushData, '0);
        else begin
          string t;
          logic [DW-1:0] e;
          e = expOb.pop_front();
          t = expObTag.pop_front();
          check(obPushData == e, t, obPushData, e);
        end
      end
      if (ibPush) begin
        check(ibPushData != INVALID, "R10 invalid marker fetched", ibPushData, ~INVALID);
        if (expIb.size() == 0) check(1'b0, "R7 unexpected inbound push", ibPushData, '0);
        else begin
          string t;
          logic [DW-1:0] e;
          e = expIb.pop_front();
          t = expIbTag.pop_front();
          check(ibPushData == e, t, ibPushData, e);
        end
      end
    end
  end

  // Driver tasks
  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cpuWrEn <= 1'b1; cpuWrAddr <= a; cpuWrData <= d;
    @(negedge clk);
    cpuWrEn <= 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectReq(input logic [DW-1:0] d, input string t);
    expReq.push_back(d); expReqTag.push_back(t);
  endtask

  task automatic expectOb(input logic [DW-1:0] d, input string t);
    expOb.push_back(d); expObTag.push_back(t);
  endtask

  task automatic expectIb(input logic [DW-1:0] d, input string t);
    expIb.push_back(d); expIbTag.push_back(t);
  endtask

  task automatic loadRsp(input int c, input logic [DW-1:0] d);
    @(negedge clk);
    rspMem[c][rspCnt[c] % RSP_DEPTH] <= d;
    rspCnt[c] <= rspCnt[c] + 1;
  endtask

  task automatic drained(input string t);
    check(expReq.size() == 0, {t, " pending requests left"}, DW'(expReq.size()), '0);
    check(expOb.size() == 0, {t, " pending outbound left"}, DW'(expOb.size()), '0);
    check(expIb.size() == 0, {t, " pending inbound left"}, DW'(expIb.size()), '0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    // R9: reset state
    repeat (2) @(negedge clk);
    check(chReq == '0 && chFetch == '0, "R9 channel strobes in reset", DW'({chReq, chFetch}), '0);
    check(!obPush && !obPop && !ibPush, "R9 mailbox strobes in reset", DW'({obPush, obPop, ibPush}), '0);
    rstN <= 1'b1;
    idle(2);

    // R5: direct delivery to idle channels, including channel 0 and last channel
    expectReq(32'hCAFE_0002, "R5 direct ch2");
    wr(8'hA0, 32'hCAFE_0002);
    expectReq(32'h0BAD_0008, "R5 direct ch8 at 0xAC");
    wr(8'hAC, 32'h0BAD_0008);
    expectReq(32'h1357_9BD0, "R5 direct ch0 at 0xA4");
    wr(8'hA4, 32'h1357_9BD0);
    idle(3);
    drained("R5");

    // R1: writes outside the window do nothing
    wr(8'h90, 32'h0000_0001);
    wr(8'hA2, 32'h0000_0001);
    wr(8'hB0, 32'h0000_0001);
    wr(8'h9C, 32'h0000_0001);
    idle(3);
    drained("R1");
    check(obCnt == 0, "R1 outbound untouched", DW'(obCnt), '0);

    // R3: tags at or above channel count are dropped
    wr(8'hA0, 32'h5555_0009);
    wr(8'hA8, 32'h5555_000F);
    idle(3);
    drained("R3");
    check(obCnt == 0, "R3 outbound untouched", DW'(obCnt), '0);

    // R4: busy channel diverts words into outbound mailbox
    @(negedge clk); chBusy[3] <= 1'b1;
    for (int k = 0; k < OB_DEPTH; k++) begin
      expectOb(32'hB000_0003 | (DW'(k) << 8), "R4 queue busy ch3");
      wr(8'hA0, 32'hB000_0003 | (DW'(k) << 8));
    end
    idle(2);
    check(obCnt == OB_DEPTH, "R4 outbound filled", DW'(obCnt), DW'(OB_DEPTH));

    // R2: outbound full drops requests, busy or idle target
    wr(8'hA0, 32'hDEAD_0003);
    wr(8'hA4, 32'hDEAD_0005);
    idle(3);
    drained("R2");
    check(obCnt == OB_DEPTH, "R2 outbound unchanged when full", DW'(obCnt), DW'(OB_DEPTH));

    // R8: release busy, queued words forwarded in order
    for (int k = 0; k < OB_DEPTH; k++) expectReq(32'hB000_0003 | (DW'(k) << 8), "R8 forward oldest first");
    @(negedge clk); chBusy[3] <= 1'b0;
    idle(6);
    drained("R8");
    check(obCnt == 0, "R8 outbound emptied", DW'(obCnt), '0);

    // R8: a pending request wins the cycle over forwarding
    @(negedge clk); chBusy[3] <= 1'b1;
    expectOb(32'hA100_0003, "R8 setup queue 1");
    wr(8'hA0, 32'hA100_0003);
    expectOb(32'hA200_0003, "R8 setup queue 2");
    wr(8'hA0, 32'hA200_0003);
    idle(2);
    expectReq(32'hA100_0003, "R8 first forward");
    expectReq(32'hC600_0006, "R8 pending request first");
    expectReq(32'hA200_0003, "R8 second forward after yield");
    @(negedge clk);
    chBusy[3] <= 1'b0;
    cpuWrEn <= 1'b1; cpuWrAddr <= 8'hA0; cpuWrData <= 32'hC600_0006;
    @(negedge clk);
    cpuWrEn <= 1'b0;
    idle(5);
    drained("R8 yield");

    // R6: ascending order, each channel drained before the next
    @(negedge clk); holdRsp <= 1'b1;
    loadRsp(4, 32'h4444_0004);
    loadRsp(1, 32'h1111_0A01);
    loadRsp(1, 32'h1111_0B01);
    loadRsp(0, 32'h0000_0C00);
    expectIb(32'h0000_0C00, "R6 ch0 first");
    expectIb(32'h1111_0A01, "R6 ch1 word 1");
    expectIb(32'h1111_0B01, "R6 ch1 word 2");
    expectIb(32'h4444_0004, "R6 ch4 last");
    @(negedge clk); holdRsp <= 1'b0;
    idle(8);
    drained("R6");
    check(ibCnt == IB_DEPTH, "R6 inbound count", DW'(ibCnt), DW'(IB_DEPTH));

    // R7: inbound full blocks fetches
    loadRsp(2, 32'h2222_0D02);
    loadRsp(2, 32'h2222_0E02);
    idle(5);
    check(rspRd[2] == 0, "R7 no fetch while full", DW'(rspRd[2]), '0);
    check(ibCnt == IB_DEPTH, "R7 inbound unchanged", DW'(ibCnt), DW'(IB_DEPTH));
    expectIb(32'h2222_0D02, "R7 resume word 1");
    expectIb(32'h2222_0E02, "R7 resume word 2");
    @(negedge clk); ibCnt <= 0;
    idle(5);
    drained("R7");
    check(rspRd[2] == 2, "R7 channel drained after space", DW'(rspRd[2]), DW'(2));
    check(ibCnt == 2, "R10 only valid words counted", DW'(ibCnt), DW'(2));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule